// File: doc/BRIEF.md
# Transmit Mailbox Status and Allocation

This block keeps track of which of three transmit mailboxes hold a pending frame. It turns that state into the status byte that software polls before it loads a new frame. Register-write logic sends a one-cycle request pulse when software asks a mailbox to send. The transmitter sends a one-cycle pulse when a mailbox's frame has gone out or has been aborted. A priority key for each mailbox comes in on a live input bus.

From the pending set and the keys, the block produces four outputs:
- an empty flag for each mailbox;
- a lowest-priority marker, which names the pending mailbox that will be served last when more than one is waiting;
- a two-bit pointer that tells software which mailbox to fill next;
- all of the above packed into the top byte of a 32-bit status word.

Message storage, bus arbitration and frame serialization live elsewhere.

Top module: `txSlotStatus`

## Requirements
- R1: After reset all three empty flags are 1, all lowest-priority flags are 0 and the next-mailbox pointer is 00.
- R2: A request pulse to an empty mailbox clears that mailbox's empty flag on the first clock edge after the pulse.
- R3: A completion/abort pulse to a pending mailbox sets its empty flag on the first clock edge after the pulse. This holds even if a request pulse hits the same mailbox in the same cycle.
- R4: A request pulse to a mailbox that is already pending changes no output.
- R5: A lowest-priority flag is 1 only when two or more mailboxes are pending, and then only for the pending mailbox with the largest key (a larger key means lower priority). At most one flag is 1.
- R6: Among pending mailboxes with equal keys, the higher-numbered one ranks lower in priority.
- R7: When any mailbox is empty, the pointer names the lowest-numbered empty mailbox. A single request from the all-idle state therefore moves it from 00 to 01.
- R8: When all three mailboxes are pending, the pointer names the pending mailbox with the smallest key, with ties going to the lower number.
- R9: The status word carries the lowest-priority flags of mailboxes 2,1,0 in bits 31,30,29. It carries the empty flags of mailboxes 2,1,0 in bits 28,27,26 and the pointer in bits 25:24. Bits 23:0 read 0.
- R10: The key of mailbox i is prioKey[i*KEY_W +: KEY_W]. A key change updates the flags and the pointer in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqPulse | input | 3 | One-cycle transmit request, one bit per mailbox |
| donePulse | input | 3 | One-cycle completion or abort, one bit per mailbox |
| prioKey | input | 3*KEY_W | Priority keys, mailbox i at bits i*KEY_W +: KEY_W |
| emptyFlags | output | 3 | 1 while the mailbox has no pending frame |
| lowPrioFlags | output | 3 | Marks the lowest-priority pending mailbox |
| nextSlot | output | 2 | Mailbox software should use next |
| statusWord | output | 32 | Packed status as laid out in R9 |

## Verification
The hardest case to reach from the ports is one where several mailboxes are pending and keys collide, so that the tie rules decide both the marker and the full-state pointer. The bench narrows keys to two bits. It drives every one of the eight pending patterns through the request and completion pulses. For each pattern it sweeps all 64 key combinations without clocking, so that every tie and every ordering is compared against an arithmetic ranking. It also fires redundant requests, and requests that coincide with completions, on every pattern.

// File: rtl/txslot_pkg.sv
package txslot_pkg;
  localparam int NUM_TX_SLOTS = 3;
  localparam int SLOT_IDX_W   = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_TX_SLOTS-1:0] setPend;
    logic [NUM_TX_SLOTS-1:0] clrPend;
  } slotStrobe_t;
endpackage

// File: rtl/txslot_ctrl.sv
module txslot_ctrl
  import txslot_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_TX_SLOTS-1:0] reqPulse,
  input  logic [NUM_TX_SLOTS-1:0] donePulse,
  input  logic [NUM_TX_SLOTS-1:0] pendingQ,
  output slotStrobe_t             strobe
);
  // A request only takes on an empty slot; a completion only frees a busy one.
  always_comb begin
    strobe.setPend = reqPulse & ~pendingQ;
    strobe.clrPend = donePulse & pendingQ;
  end

  // R3: a freed slot stays pending no longer than one edge
  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|(donePulse & pendingQ)) |=> ((pendingQ & $past(donePulse & pendingQ)) == '0));

  // R4: a redundant request leaves a busy slot busy unless freed
  p_req_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|(reqPulse & pendingQ & ~donePulse)) |=>
      ((pendingQ & $past(reqPulse & pendingQ & ~donePulse)) == $past(reqPulse & pendingQ & ~donePulse)));
endmodule

// File: rtl/txslot_datapath.sv
module txslot_datapath
  import txslot_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  slotStrobe_t                   strobe,
  input  logic [NUM_TX_SLOTS*KEY_W-1:0] prioKey,
  output logic [NUM_TX_SLOTS-1:0]       pendingQ,
  output logic [NUM_TX_SLOTS-1:0]       lowPrio,
  output logic [SLOT_IDX_W-1:0]         nextSlot
);
  logic [KEY_W-1:0]        keyArr [NUM_TX_SLOTS];
  logic [NUM_TX_SLOTS-1:0] lowCand;
  logic [NUM_TX_SLOTS-1:0] hiCand;
  logic                    multiPending;
  logic [SLOT_IDX_W-1:0]   firstEmpty;
  logic [SLOT_IDX_W-1:0]   bestSlot;

  for (genvar g = 0; g < NUM_TX_SLOTS; g++) begin : g_key
    assign keyArr[g] = prioKey[g*KEY_W +: KEY_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendingQ <= '0;
    else       pendingQ <= (pendingQ & ~strobe.clrPend) | strobe.setPend;
  end

  // Pairwise ranking: slot i outranks j on smaller key, lower index on tie.
  always_comb begin
    int cnt;
    cnt = 0;
    for (int i = 0; i < NUM_TX_SLOTS; i++) begin
      lowCand[i] = pendingQ[i];
      hiCand[i]  = pendingQ[i];
      if (pendingQ[i]) cnt++;
      for (int j = 0; j < NUM_TX_SLOTS; j++) begin
        if (j != i && pendingQ[j]) begin
          if ((keyArr[i] < keyArr[j]) || ((keyArr[i] == keyArr[j]) && (i < j)))
            lowCand[i] = 1'b0;
          else
            hiCand[i] = 1'b0;
        end
      end
    end
    multiPending = (cnt > 1);
    lowPrio      = multiPending ? lowCand : '0;
  end

  always_comb begin
    firstEmpty = '0;
    bestSlot   = '0;
    for (int i = NUM_TX_SLOTS-1; i >= 0; i--) begin
      if (!pendingQ[i]) firstEmpty = SLOT_IDX_W'(i);
      if (hiCand[i])    bestSlot   = SLOT_IDX_W'(i);
    end
    nextSlot = (&pendingQ) ? bestSlot : firstEmpty;
  end

  // R5: marker is one-hot, on a pending slot, and only with several pending
  p_low_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lowPrio) && ((lowPrio & ~pendingQ) == '0));
  p_low_needs_two_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lowPrio != '0) |-> ($countones(pendingQ) > 1));
  // R8: with all busy the pointer names a slot that is not the lowest
  p_full_next_r8: assert property (@(posedge clk) disable iff (!rstN)
    (&pendingQ) |-> !lowPrio[nextSlot]);
endmodule

// File: rtl/txSlotStatus.sv
module txSlotStatus
  import txslot_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_TX_SLOTS-1:0]       reqPulse,
  input  logic [NUM_TX_SLOTS-1:0]       donePulse,
  input  logic [NUM_TX_SLOTS*KEY_W-1:0] prioKey,
  output logic [NUM_TX_SLOTS-1:0]       emptyFlags,
  output logic [NUM_TX_SLOTS-1:0]       lowPrioFlags,
  output logic [SLOT_IDX_W-1:0]         nextSlot,
  output logic [31:0]                   statusWord
);
  localparam int LOW_MSB   = 31;
  localparam int EMPTY_MSB = LOW_MSB - NUM_TX_SLOTS;
  localparam int NEXT_MSB  = EMPTY_MSB - NUM_TX_SLOTS;
  localparam int FREE_MSB  = NEXT_MSB - SLOT_IDX_W;

  slotStrobe_t             strobe;
  logic [NUM_TX_SLOTS-1:0] pendingQ;

  txslot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqPulse(reqPulse), .donePulse(donePulse),
    .pendingQ(pendingQ), .strobe(strobe)
  );

  txslot_datapath #(.KEY_W(KEY_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prioKey(prioKey),
    .pendingQ(pendingQ), .lowPrio(lowPrioFlags), .nextSlot(nextSlot)
  );

  assign emptyFlags = ~pendingQ;

  always_comb begin
    statusWord = '0;
    statusWord[LOW_MSB   -: NUM_TX_SLOTS] = lowPrioFlags;
    statusWord[EMPTY_MSB -: NUM_TX_SLOTS] = emptyFlags;
    statusWord[NEXT_MSB  -: SLOT_IDX_W]   = nextSlot;
  end

  // R2: request to an empty slot occupies it at the next edge
  p_req_takes_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|(reqPulse & emptyFlags)) |=> ((emptyFlags & $past(reqPulse & emptyFlags)) == '0));
  // R7: pointer names an empty slot whenever one exists
  p_next_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|emptyFlags) |-> emptyFlags[nextSlot]);
  // R9: low bits of the status word stay clear
  p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[FREE_MSB:0] == '0);
endmodule

// File: tb/txSlotStatus_tb.sv
module txSlotStatus_tb_top;
  localparam int KW = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   reqPulse = '0;
  logic [2:0]   donePulse = '0;
  logic [3*KW-1:0] prioKey = '0;
  logic [2:0]   emptyFlags, lowPrioFlags;
  logic [1:0]   nextSlot;
  logic [31:0]  statusWord;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  txSlotStatus #(.KEY_W(KW)) dut_i (
    .clk(clk), .rstN(rstN), .reqPulse(reqPulse), .donePulse(donePulse),
    .prioKey(prioKey), .emptyFlags(emptyFlags), .lowPrioFlags(lowPrioFlags),
    .nextSlot(nextSlot), .statusWord(statusWord)
  );

  always #10 clk = ~clk;

  // Expected top byte {low[2:0], empty[2:0], next[1:0]} from a rank weight
  // key*4+index: larger weight = lower priority (R5, R6, R8).
  function automatic logic [7:0] model(input logic [2:0] pend, input logic [3*KW-1:0] keys);
    int w [3];
    int maxW = -1, minW = 1000, maxI = 0, minI = 0, cnt = 0;
    logic [2:0] low = '0;
    logic [1:0] nxt = '0;
    for (int i = 0; i < 3; i++) begin
      w[i] = int'(keys[i*KW +: KW]) * 4 + i;
      if (pend[i]) begin
        cnt++;
        if (w[i] > maxW) begin maxW = w[i]; maxI = i; end
        if (w[i] < minW) begin minW = w[i]; minI = i; end
      end
    end
    if (cnt > 1) low[maxI] = 1'b1;
    if (pend == 3'b111) nxt = 2'(minI);
    else if (!pend[0])  nxt = 2'd0;
    else if (!pend[1])  nxt = 2'd1;
    else                nxt = 2'd2;
    return {low, ~pend, nxt};
  endfunction

  task automatic check(input string tag, input logic [2:0] pend);
    logic [7:0] exp;
    exp = model(pend, prioKey);
    testCount++;
    if (statusWord[31:24] !== exp || statusWord[23:0] !== 24'd0 ||
        {lowPrioFlags, emptyFlags, nextSlot} !== exp) begin
      failCount++;
      $display("FAIL %s pend=%b keys=%h actual=%h ports=%b expected=%h", tag, pend, prioKey,
               statusWord, {lowPrioFlags, emptyFlags, nextSlot}, {exp, 24'd0});
    end
  endtask

  task automatic pulse(input logic [2:0] r, input logic [2:0] d);
    @(negedge clk);
    reqPulse = r; donePulse = d;
    @(negedge clk);
    reqPulse = '0; donePulse = '0;
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    failCount++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 reset", 3'b000);

    // R7/R2: single request from idle steps pointer 00 -> 01 -> 10, then full
    prioKey = 6'b10_01_11;
    pulse(3'b001, 3'b000); check("R7 R2 step1", 3'b001);
    if (nextSlot !== 2'b01) begin failCount++; $display("FAIL R7 actual=%b expected=01", nextSlot); end
    testCount++;
    pulse(3'b010, 3'b000); check("R7 R2 step2", 3'b011);
    pulse(3'b100, 3'b000); check("R8 full", 3'b111);

    for (int p = 0; p < 8; p++) begin
      pulse(3'b000, 3'b111); check("R3 free all", 3'b000);
      pulse(3'(p), 3'b000);  check("R2 load", 3'(p));
      // R10: keys swept with no clock edge; R5 R6 R8 R9 compared each time
      for (int k = 0; k < 64; k++) begin
        prioKey = 6'(k);
        #1;
        check("R5 R6 R8 R9 R10 sweep", 3'(p));
      end
      prioKey = 6'b01_01_00;
      // R4: redundant request to the pending slots changes nothing
      pulse(3'(p), 3'b000); check("R4 redundant", 3'(p));
      // R3: request with completion on the same pending slots frees them
      pulse(3'(p), 3'(p));  check("R3 done wins", 3'b000);
      // R2 partial: request every slot with nothing pending
      pulse(3'b111, 3'b000); check("R2 all", 3'b111);
    end
    finish_run();
  end
endmodule